// File: doc/BRIEF.md
# Clock-Phase Interleaved DRAM Controller

This block lets an 8-bit processor with a regular two-phase bus use asynchronous DRAM with a multiplexed address. The processor never waits. Each processor clock cycle is split into its two halves. While the processor clock is low, the block runs a refresh cycle. While the clock is high, it runs the processor's own read or write. Refresh therefore never delays or stretches a processor access.

All sequencing runs on a faster timing clock. The processor clock is sampled in that domain, and a tick counter restarts at every phase change. Two sources can drive the eight DRAM address lines, and only one of them is enabled at a time. The first is a row/column multiplexer fed from the processor address. The second is an 8-bit refresh row counter. When neither source is enabled, the address lines are parked at zero.

The row map places processor address bits 14 and 15 on the outer row lines. This lets a 16K x 4 device, which decodes only row lines 1 to 6, and a 64K x 4 device share the same wiring. A build-time option replaces RAS-only refresh with CAS-before-RAS refresh, which uses the counter inside the device.

Top module: `dram_phase_ctrl`

## Requirements
- R1: Refresh activity (counter address with RAS low) occurs only in the low processor-clock phase. Processor accesses, and with them write enable and the buffer enable, occur only in the high phase.
- R2: In the default mode, ticks 0 to 5 of the low phase drive the refresh row on the address lines with RAS low and CAS high. Tick 0 is the first timing-clock edge that sees the new phase. Each output appears one timing-clock edge after the tick that produces it.
- R3: The refresh row counter starts at 0, advances by exactly one at the end of every refresh slot, and wraps from 255 to 0.
- R4: With chip select active in the high phase, RAS falls at tick 0 and CAS falls at tick 2. Both strobes return high at tick 6, which is before the processor clock falls.
- R5: The row address is {A15, A13..A8, A14}, with A14 on line 0 and A15 on line 7, and it is driven at tick 0. The column address is A7..A0 on lines 7..0, driven from tick 1 onward.
- R6: On a write (readNotWrite = 0), weN goes low together with RAS, before CAS falls, and stays low only while RAS is low.
- R7: bufEn is high only on a read, and only while CAS is low (ticks 2 to 5 of the high phase).
- R8: With chip select inactive in the high phase, RAS and CAS stay high, weN stays high, bufEn stays low and the address lines stay at 0.
- R9: With CBR_REFRESH = 1, the low phase drives CAS low at ticks 0 to 5 and RAS low at ticks 1 to 5, so CAS falls before RAS.
- R10: During reset, RAS, CAS and weN are high, bufEn is low and the address lines are 0.
- R11: Every one of the 256 rows gets a RAS strobe within any window of 256 processor cycles. Meanwhile, interleaved processor writes and reads return the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Timing clock for the strobe sequence |
| rstN | input | 1 | Active-low synchronous reset |
| cpuClk | input | 1 | Processor clock; high half for access, low half for refresh |
| cpuAddr | input | 16 | Processor address |
| readNotWrite | input | 1 | 1 for read, 0 for write |
| chipSel | input | 1 | Active-high select for the DRAM region |
| dramAddr | output | 8 | Multiplexed DRAM address lines |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bufEn | output | 1 | Read data-buffer enable, active high |

## Verification
The assertions assume two things about the processor clock. First, it changes in step with the timing clock. Second, each half lasts at least seven timing ticks, so the six-tick strobe window always finishes inside its phase. They also assume that address, chip select and read/write change only at the falling processor-clock edge and then hold through the following high phase. The stimulus toggles the processor clock every eight timing ticks on the inactive timing-clock edge. It changes the bus inputs only at that falling transition, and it mixes directed boundary addresses with random selects, directions and addresses over more than two counter wraps.

// File: rtl/dram_phase_pkg.sv
package dram_phase_pkg;
  // Strobe requests from the sequencer to the address/strobe datapath.
  typedef struct packed {
    logic rasOn;   // assert row strobe
    logic casOn;   // assert column strobe
    logic weOn;    // assert write enable
    logic bufOn;   // enable read data buffer
    logic drvCpu;  // enable processor row/column multiplexer
    logic useCol;  // multiplexer selects column half
    logic drvRef;  // enable refresh counter buffer
    logic advRef;  // step refresh counter
  } strobe_t;
endpackage

// File: rtl/dram_phase_seq.sv
module dram_phase_seq
  import dram_phase_pkg::*;
#(
  parameter int HALF_TICKS  = 8,
  parameter int COL_TICK    = 1,
  parameter int CAS_TICK    = 2,
  parameter int END_TICK    = 6,
  parameter bit CBR_REFRESH = 1'b0
) (
  input  logic    fastClk,
  input  logic    rstN,
  input  logic    cpuClk,
  input  logic    chipSel,
  input  logic    readNotWrite,
  output strobe_t strb
);
  localparam int TICK_W = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(HALF_TICKS - 1);
  localparam logic [TICK_W-1:0] T_COL    = TICK_W'(COL_TICK);
  localparam logic [TICK_W-1:0] T_CAS    = TICK_W'(CAS_TICK);
  localparam logic [TICK_W-1:0] T_END    = TICK_W'(END_TICK);
  localparam logic [TICK_W-1:0] T_ONE    = TICK_W'(1);

  logic              phaseQ;
  logic [TICK_W-1:0] tick;
  logic              inWindow;

  always_ff @(posedge fastClk) begin
    if (!rstN) begin
      phaseQ <= 1'b1;
      tick   <= TICK_MAX;
    end else begin
      phaseQ <= cpuClk;
      if (cpuClk != phaseQ) tick <= '0;
      else if (tick != TICK_MAX) tick <= tick + T_ONE;
    end
  end

  assign inWindow = (tick < T_END);

  always_comb begin
    strb = '0;
    if (phaseQ) begin
      if (chipSel && inWindow) begin
        strb.rasOn  = 1'b1;
        strb.drvCpu = 1'b1;
        strb.useCol = (tick >= T_COL);
        strb.casOn  = (tick >= T_CAS);
        strb.weOn   = !readNotWrite;
        strb.bufOn  = readNotWrite && (tick >= T_CAS);
      end
    end else begin
      if (inWindow) begin
        strb.drvRef = 1'b1;
        if (CBR_REFRESH) begin
          strb.casOn = 1'b1;
          strb.rasOn = (tick >= T_ONE);
        end else begin
          strb.rasOn = 1'b1;
        end
      end
      strb.advRef = (tick == T_END);
    end
  end
endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_phase_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MA_W   = 8
) (
  input  logic              fastClk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [MA_W-1:0]   dramAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              bufEn,
  output logic [MA_W-1:0]   refRow
);
  localparam int MID_W = MA_W - 2;   // row lines fed from the middle address bits
  localparam int HI_B  = ADDR_W - 1; // top processor address bit
  localparam int LO_B  = ADDR_W - 2; // next processor address bit

  logic [MA_W-1:0] rowAddr, colAddr, cpuSrc, busNext;

  // Row map keeps both density variants on one wiring: outer lines take the
  // two top processor bits, the inner lines take the bits above the column.
  assign rowAddr = {cpuAddr[HI_B], cpuAddr[MA_W +: MID_W], cpuAddr[LO_B]};
  assign colAddr = cpuAddr[MA_W-1:0];
  assign cpuSrc  = strb.useCol ? colAddr : rowAddr;

  // Two enabled sources on one bus; lines parked at zero when neither drives.
  always_comb begin
    busNext = '0;
    if (strb.drvCpu)      busNext = cpuSrc;
    else if (strb.drvRef) busNext = refRow;
  end

  always_ff @(posedge fastClk) begin
    if (!rstN) begin
      refRow   <= '0;
      dramAddr <= '0;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      weN      <= 1'b1;
      bufEn    <= 1'b0;
    end else begin
      if (strb.advRef) refRow <= refRow + MA_W'(1);
      dramAddr <= busNext;
      rasN     <= !strb.rasOn;
      casN     <= !strb.casOn;
      weN      <= !strb.weOn;
      bufEn    <= strb.bufOn;
    end
  end
endmodule

// File: rtl/dram_phase_ctrl.sv
module dram_phase_ctrl
  import dram_phase_pkg::*;
#(
  parameter int HALF_TICKS  = 8,
  parameter int COL_TICK    = 1,
  parameter int CAS_TICK    = 2,
  parameter int END_TICK    = 6,
  parameter bit CBR_REFRESH = 1'b0,
  parameter int ADDR_W      = 16,
  parameter int MA_W        = 8
) (
  input  logic              fastClk,
  input  logic              rstN,
  input  logic              cpuClk,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              readNotWrite,
  input  logic              chipSel,
  output logic [MA_W-1:0]   dramAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              bufEn
);
  strobe_t         strb;
  logic [MA_W-1:0] refRow;

  dram_phase_seq #(
    .HALF_TICKS(HALF_TICKS), .COL_TICK(COL_TICK), .CAS_TICK(CAS_TICK),
    .END_TICK(END_TICK), .CBR_REFRESH(CBR_REFRESH)
  ) seq_i (
    .fastClk(fastClk), .rstN(rstN), .cpuClk(cpuClk), .chipSel(chipSel),
    .readNotWrite(readNotWrite), .strb(strb)
  );

  dram_addr_path #(.ADDR_W(ADDR_W), .MA_W(MA_W)) path_i (
    .fastClk(fastClk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .dramAddr(dramAddr), .rasN(rasN), .casN(casN), .weN(weN),
    .bufEn(bufEn), .refRow(refRow)
  );
endmodule

// File: rtl/dram_phase_chk.sv
module dram_phase_chk #(
  parameter bit CBR_REFRESH = 1'b0,
  parameter int MA_W        = 8
) (
  input logic            fastClk,
  input logic            rstN,
  input logic            cpuClk,
  input logic            chipSel,
  input logic            rasN,
  input logic            casN,
  input logic            weN,
  input logic            bufEn,
  input logic [MA_W-1:0] refRow
);
  // R1: outside CBR mode a column strobe never appears without a row strobe
  assert_cas_needs_ras_R1: assert property (@(posedge fastClk) disable iff (!rstN)
    (!CBR_REFRESH && !casN) |-> !rasN);

  // R6: write enable falls while CAS is still high and only inside a RAS window
  assert_we_early_R6: assert property (@(posedge fastClk) disable iff (!rstN)
    $fell(weN) |-> casN);
  assert_we_in_ras_R6: assert property (@(posedge fastClk) disable iff (!rstN)
    !weN |-> !rasN);

  // R7: buffer enable only on a read with CAS low
  assert_buf_read_R7: assert property (@(posedge fastClk) disable iff (!rstN)
    bufEn |-> (!casN && weN));

  // R3: refresh row moves only by single steps, wrapping naturally
  assert_ref_step_R3: assert property (@(posedge fastClk) disable iff (!rstN)
    (refRow != $past(refRow)) |-> (refRow == $past(refRow) + MA_W'(1)));

  // R8: deselected high phase issues no strobes
  assert_idle_deselect_R8: assert property (@(posedge fastClk) disable iff (!rstN)
    (cpuClk && $past(cpuClk) && !chipSel) |-> (rasN && casN));

  // R4: CAS is already high when RAS returns high
  assert_strobes_close_R4: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(rasN) |-> casN);
endmodule

bind dram_phase_ctrl dram_phase_chk #(.CBR_REFRESH(CBR_REFRESH), .MA_W(MA_W)) chk_i (
  .fastClk(fastClk), .rstN(rstN), .cpuClk(cpuClk), .chipSel(chipSel),
  .rasN(rasN), .casN(casN), .weN(weN), .bufEn(bufEn), .refRow(refRow)
);

// File: tb/dram_phase_ctrl_tb_top.sv
module dram_phase_ctrl_tb_top;
  localparam int FAST_PERIOD = 10;
  localparam int HALF        = 8;
  localparam int RAND_CYCLES = 620;

  logic        fastClk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuClk = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic        readNotWrite = 1'b1;
  logic        chipSel = 1'b0;
  logic [7:0]  dramAddr, cbrAddr;
  logic        rasN, casN, weN, bufEn;
  logic        cbrRasN, cbrCasN, cbrWeN, cbrBufEn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model state
  int        refRowExp = 0;
  int        cycleNum = 0;
  int        lastRef [256];
  logic [7:0] memModel [int];
  logic [7:0] scoreboard [int];
  logic [7:0] wrData = '0;
  logic [7:0] readVal;
  int        latRow = 0;
  logic      prevRas = 1'b1, prevCas = 1'b1;

  always #(FAST_PERIOD/2) fastClk = ~fastClk;

  dram_phase_ctrl dut_i (
    .fastClk(fastClk), .rstN(rstN), .cpuClk(cpuClk), .cpuAddr(cpuAddr),
    .readNotWrite(readNotWrite), .chipSel(chipSel), .dramAddr(dramAddr),
    .rasN(rasN), .casN(casN), .weN(weN), .bufEn(bufEn)
  );

  dram_phase_ctrl #(.CBR_REFRESH(1'b1)) dut_cbr_i (
    .fastClk(fastClk), .rstN(rstN), .cpuClk(cpuClk), .cpuAddr(cpuAddr),
    .readNotWrite(readNotWrite), .chipSel(chipSel), .dramAddr(cbrAddr),
    .rasN(cbrRasN), .casN(cbrCasN), .weN(cbrWeN), .bufEn(cbrBufEn)
  );

  task automatic checkOne(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycleNum);
    end
  endtask

  // t = tick whose effect is visible now (outputs lag their tick by one edge)
  task automatic checkPins(input bit hi, input int t);
    logic eRas, eCas, eWe, eBuf;
    int   eAddr;
    string tagRc, tagAd;
    eRas = 1; eCas = 1; eWe = 1; eBuf = 0; eAddr = 0;
    if (t >= 0 && t <= 5) begin
      if (!hi) begin
        eRas = 0; eAddr = refRowExp;
      end else if (chipSel) begin
        eRas = 0;
        eAddr = (t == 0) ? {cpuAddr[15], cpuAddr[13:8], cpuAddr[14]} : cpuAddr[7:0];
        if (t >= 2) eCas = 0;
        if (!readNotWrite) eWe = 0;
        if (readNotWrite && t >= 2) eBuf = 1;
      end
    end
    tagRc = !hi ? "R2" : (chipSel ? "R4" : "R8");
    tagAd = !hi ? "R3" : (chipSel ? "R5" : "R8");
    checkOne(tagRc, "rasN", rasN, eRas);
    checkOne(tagRc, "casN", casN, eCas);
    checkOne(tagAd, "dramAddr", dramAddr, eAddr);
    checkOne("R6", "weN", weN, eWe);
    checkOne("R7", "bufEn", bufEn, eBuf);
    if (!hi) begin
      // R1: no processor-side strobes in the refresh half
      checkOne("R1", "weN/bufEn low phase", {weN, bufEn}, 2'b10);
      // R9: CAS-before-RAS variant
      checkOne("R9", "cbr casN", cbrCasN, (t >= 0 && t <= 5) ? 0 : 1);
      checkOne("R9", "cbr rasN", cbrRasN, (t >= 1 && t <= 5) ? 0 : 1);
    end
    // simple DRAM model driven by the pins
    if (prevRas && !rasN) begin
      latRow = dramAddr;
      if (casN) lastRef[dramAddr] = cycleNum;
    end
    if (prevCas && !casN && !rasN) begin
      if (!weN) memModel[{latRow[7:0], dramAddr}] = wrData;
      else if (memModel.exists({latRow[7:0], dramAddr})) readVal = memModel[{latRow[7:0], dramAddr}];
    end
    prevRas = rasN;
    prevCas = casN;
  endtask

  task automatic halfPhase(input bit hi);
    for (int n = 1; n <= HALF; n++) begin
      @(posedge fastClk);
      @(negedge fastClk);
      checkPins(hi, n - 2);
    end
  endtask

  task automatic runCycle(input logic cs, input logic rnw, input logic [15:0] a, input logic [7:0] d);
    cpuClk = 1'b0;
    chipSel = cs; readNotWrite = rnw; cpuAddr = a; wrData = d;
    readVal = 'x;
    halfPhase(1'b0);
    refRowExp = (refRowExp + 1) % 256;
    cpuClk = 1'b1;
    halfPhase(1'b1);
    if (cs && rnw && scoreboard.exists(int'(a)))
      checkOne("R11", "read data", readVal, scoreboard[int'(a)]);
    if (cs && !rnw) scoreboard[int'(a)] = d;
    cycleNum++;
    if (cycleNum >= 300 && cycleNum % 50 == 0) begin
      int stale = 0;
      for (int r = 0; r < 256; r++)
        if (cycleNum - lastRef[r] > 256) stale++;
      checkOne("R11", "rows past refresh window", stale, 0);
    end
  endtask

  initial begin
    for (int r = 0; r < 256; r++) lastRef[r] = -1000;
    repeat (4) @(posedge fastClk);
    @(negedge fastClk);
    // R10: reset state
    checkOne("R10", "rasN in reset", rasN, 1);
    checkOne("R10", "casN in reset", casN, 1);
    checkOne("R10", "weN in reset", weN, 1);
    checkOne("R10", "bufEn in reset", bufEn, 0);
    checkOne("R10", "dramAddr in reset", dramAddr, 0);
    rstN = 1'b1;
    repeat (3) @(negedge fastClk);
    // directed: addresses differing only in A14 / A15 / extremes
    runCycle(1, 0, 16'h0000, 8'h11);
    runCycle(1, 0, 16'h4000, 8'h22);
    runCycle(1, 0, 16'h8000, 8'h33);
    runCycle(1, 0, 16'hFFFF, 8'h44);
    runCycle(1, 0, 16'h3F81, 8'h55);
    runCycle(0, 0, 16'h0000, 8'hEE); // deselected write must not land (R8)
    runCycle(0, 1, 16'h4000, 8'h00);
    runCycle(1, 1, 16'h0000, 8'h00);
    runCycle(1, 1, 16'h4000, 8'h00);
    runCycle(1, 1, 16'h8000, 8'h00);
    runCycle(1, 1, 16'hFFFF, 8'h00);
    runCycle(1, 1, 16'h3F81, 8'h00);
    // random traffic over more than two counter wraps
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? 16'($urandom) : {8'($urandom % 4), 8'($urandom % 8)} ^ 16'hC0A0;
      runCycle(($urandom % 5) != 0, $urandom % 2, a, 8'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(FAST_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule